// File: doc/BRIEF.md
# Cross-Domain Event Pulse Handshake

This block carries single-cycle event pulses from a source clock domain into an unrelated destination clock domain. Nothing is assumed about the ratio of the two clocks: the source may be much faster, about the same speed, or slower than the destination. Each accepted source pulse produces exactly one destination pulse, one destination cycle wide.

The transfer uses a four-phase handshake. A source-side request flop is set by the event. The destination synchronizes the request, detects its rising edge to emit the output pulse, and returns the synchronized request level through an acknowledge flop. The source clears the request once it sees the acknowledge high. It reports itself free once the acknowledge has fallen again.

While a transfer is in flight the source-side busy flag is high, and further source pulses are dropped. Logic that must not lose events should hold them until busy is low. The single active-low reset asserts asynchronously in both domains. It is expected to be released cleanly with respect to both clocks.

Top module: `pulse_xfer_hs`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, `dst_pulse` and `src_busy` are low.
- R2: A `src_pulse` that is high at a `src_clk` rising edge while `src_busy` is low is accepted, and `src_busy` is high after that edge.
- R3: Each accepted source pulse produces exactly one `dst_pulse`, for a destination clock slower than, equal to, or faster than the source clock.
- R4: `dst_pulse` is never high on two consecutive `dst_clk` cycles.
- R5: `src_busy` falls only after the destination pulse for the current transfer has been produced and the returned acknowledge has gone low again.
- R6: A `src_pulse` that is high while `src_busy` is high is ignored: no additional `dst_pulse` appears and `src_busy` is not extended.
- R7: After an accepted pulse, `src_busy` returns low within 8 source cycles plus 8 destination cycles.
- R8: A pulse presented on the first source cycle in which `src_busy` is low again is accepted and transferred like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| dst_clk | input | 1 | Destination domain clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, both domains |
| src_pulse | input | 1 | Event pulse, source domain |
| dst_pulse | output | 1 | One-cycle event pulse, destination domain |
| src_busy | output | 1 | Transfer in flight; new source pulses are ignored while high |

## Verification
The main transfer is tried with the destination clock about three times slower than the source, at the same rate, and nearly three times faster. These cases separate a design that depends on one clock outrunning the other from one that is correct at any ratio. Isolated pulses show the basic one-in, one-out behaviour. Extra pulses injected while busy is high show whether busy actually gates acceptance. A pulse issued on the very first free cycle shows that the handshake returns fully to idle with no dead cycle and no stale acknowledge.

// File: rtl/pxh_pkg.sv
package pxh_pkg;

  // Default number of flops in each clock-crossing synchronizer chain.
  localparam int unsigned PXH_SYNC_DEPTH = 2;

  // Source-side handshake phases.
  typedef enum logic [1:0] {
    HS_IDLE  = 2'b00,  // free, waiting for an event
    HS_REQ   = 2'b01,  // request raised, waiting for acknowledge high
    HS_DRAIN = 2'b10   // request dropped, waiting for acknowledge low
  } hs_state_e;

endpackage

// File: rtl/pxh_sync.sv
module pxh_sync #(
  parameter int unsigned STAGES = pxh_pkg::PXH_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[LAST];

endmodule

// File: rtl/pxh_src_ctrl.sv
module pxh_src_ctrl
  import pxh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic ack_sync,
  output logic req_o,
  output logic busy_o
);

  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:  if (pulse_in)  state_d = HS_REQ;
      HS_REQ:   if (ack_sync)  state_d = HS_DRAIN;
      HS_DRAIN: if (!ack_sync) state_d = HS_IDLE;
      default:                 state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign req_o  = (state_q == HS_REQ);
  assign busy_o = (state_q != HS_IDLE);

  // R2: an event seen while free makes the block busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && pulse_in) |=> busy_o);

  // R6: events arriving in the drain phase do not restart a request
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !req_o && pulse_in) |=> !req_o);

  // R5: request stays up until the acknowledge has been seen
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_sync) |=> req_o);

  // R5: busy only falls once the acknowledge has returned low
  a_r5_busy_fall_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (!ack_sync && !req_o));

endmodule

// File: rtl/pxh_dst_ctrl.sv
module pxh_dst_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  output logic pulse_o,
  output logic ack_o
);

  logic req_prev_q;
  logic pulse_q;
  logic ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      pulse_q    <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      req_prev_q <= req_sync;
      pulse_q    <= req_sync & ~req_prev_q;
      ack_q      <= req_sync;
    end
  end

  assign pulse_o = pulse_q;
  assign ack_o   = ack_q;

  // R3: a newly arrived request is turned into an output pulse
  a_r3_rise_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_sync) |=> pulse_o);

  // R4: the output pulse is one destination cycle wide
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R5: acknowledge is raised no later than the pulse it answers
  a_r5_ack_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> ack_o);

endmodule

// File: rtl/pulse_xfer_hs.sv
module pulse_xfer_hs #(
  parameter int unsigned SYNC_STAGES = pxh_pkg::PXH_SYNC_DEPTH
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse,
  output logic src_busy
);

  logic req_src;
  logic req_dst;
  logic ack_dst;
  logic ack_src;

  pxh_src_ctrl u_src (
    .clk      (src_clk),
    .rst_n    (rst_n),
    .pulse_in (src_pulse),
    .ack_sync (ack_src),
    .req_o    (req_src),
    .busy_o   (src_busy)
  );

  pxh_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (rst_n),
    .d     (req_src),
    .q     (req_dst)
  );

  pxh_dst_ctrl u_dst (
    .clk      (dst_clk),
    .rst_n    (rst_n),
    .req_sync (req_dst),
    .pulse_o  (dst_pulse),
    .ack_o    (ack_dst)
  );

  pxh_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d     (ack_dst),
    .q     (ack_src)
  );

endmodule

// File: tb/pulse_xfer_hs_test.sv
`timescale 1ns/1ps
module pulse_xfer_hs_test;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic src_pulse = 1'b0;
  logic dst_pulse;
  logic src_busy;

  realtime dst_half = 13.0;

  int vectors = 0;
  int miscompares = 0;
  int dst_count = 0;
  int wide_err = 0;
  logic last_pulse = 1'b0;

  always #4 src_clk = ~src_clk;          // 125 MHz source clock
  always #(dst_half) dst_clk = ~dst_clk;

  pulse_xfer_hs uut (
    .src_clk   (src_clk),
    .dst_clk   (dst_clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .dst_pulse (dst_pulse),
    .src_busy  (src_busy)
  );

  // Destination-side monitor: counts pulses and flags over-wide ones (R4)
  always @(negedge dst_clk) begin
    if (rst_n) begin
      if (dst_pulse) begin
        dst_count++;
        if (last_pulse) wide_err++;
      end
      last_pulse <= dst_pulse;
    end else begin
      last_pulse <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int idle_bound();
    return 8 + int'($ceil(16.0 * dst_half / 8.0));
  endfunction

  // Present one pulse; checks acceptance when the block was free (R2)
  task automatic send_pulse(input bit expect_accept);
    @(negedge src_clk);
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
    if (expect_accept)
      check(src_busy == 1'b1, "R2 busy after accept", src_busy, 1);
  endtask

  // Wait for busy low within bound; the pulse must already be out (R5, R7)
  task automatic wait_idle(input int exp_count);
    int n = 0;
    while (src_busy && n < idle_bound() + 4) begin
      @(negedge src_clk);
      n++;
    end
    check(n <= idle_bound(), "R7 busy returns low in time", n, idle_bound());
    check(dst_count == exp_count, "R5 pulse out before busy falls", dst_count, exp_count);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    src_pulse = 1'b0;
    repeat (3) @(negedge src_clk);
    check(dst_pulse == 1'b0, "R1 dst_pulse in reset", dst_pulse, 0);
    check(src_busy == 1'b0, "R1 busy in reset", src_busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge src_clk);
    check(src_busy == 1'b0, "R1 busy after release", src_busy, 0);
    check(dst_count == 0, "R1 no pulse after release", dst_count, 0);
  endtask

  task automatic t_single(input realtime half, input string tag);
    int base;
    dst_half = half;
    repeat (4) @(negedge dst_clk);
    base = dst_count;
    send_pulse(1'b1);
    wait_idle(base + 1);
    repeat (6) @(negedge dst_clk);
    check(dst_count == base + 1, {"R3 one pulse per event ", tag}, dst_count - base, 1);
    check(wide_err == 0, {"R4 pulse width ", tag}, wide_err, 0);
  endtask

  task automatic t_ignored();
    int base = dst_count;
    send_pulse(1'b1);
    repeat (2) begin
      src_pulse = 1'b1;
      @(negedge src_clk);
      src_pulse = 1'b0;
      @(negedge src_clk);
    end
    check(src_busy == 1'b1, "R6 still busy during extra pulses", src_busy, 1);
    wait_idle(base + 1);
    repeat (8) @(negedge dst_clk);
    check(dst_count == base + 1, "R6 extra pulses ignored", dst_count - base, 1);
    check(src_busy == 1'b0, "R6 busy not extended", src_busy, 0);
  endtask

  task automatic t_back_to_back();
    int base = dst_count;
    send_pulse(1'b1);
    wait_idle(base + 1);
    // first free cycle: present the next event immediately
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
    check(src_busy == 1'b1, "R8 accepted on first free cycle", src_busy, 1);
    wait_idle(base + 2);
    repeat (6) @(negedge dst_clk);
    check(dst_count == base + 2, "R8 both events delivered", dst_count - base, 2);
    check(wide_err == 0, "R4 pulse width back to back", wide_err, 0);
  endtask

  initial begin
    t_reset();
    t_single(13.0, "slow dst");
    t_single(4.0, "equal clocks");
    t_single(1.5, "fast dst");
    dst_half = 13.0;
    t_ignored();
    dst_half = 1.5;
    t_ignored();
    dst_half = 13.0;
    t_back_to_back();
    dst_half = 1.5;
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule